// File: doc/BRIEF.md
# User-Mode Interrupt Routing Unit

This unit decides when a hart running user code takes a user-level interrupt, and with which cause code. It holds the pending and enable state for three interrupt kinds: software, timer and external. The user-visible pending and enable registers are narrowed aliases of the machine-level pair, so both views share one copy of storage. Two delegation masks are kept. The machine mask passes an interrupt down a level. The supervisor mask passes it on to the user handler, and it can only hold bits that the machine mask already passes.

Software reaches the registers through a single-cycle CSR write port and a registered read port. The timer and external pending bits are not written by software. They follow the raw input lines, sampled once per clock. On every clock the unit combines the pending, enable and delegation bits with the current privilege level and the global user interrupt enable. The result is a registered request with a cause code, for the trap logic that sits around the unit.

Top module: `uirq_route`

## Requirements
- R1: After synchronous reset, the software pending bit, the enable bits and both delegation masks are 0. `irq_req_o` is 0 and `csr_rdata_o` reads 0.
- R2: Writing the user pending view (select 0) or the machine pending view (select 2) copies write-data bit 0 into the software pending bit. Writing 1 sets it, writing 0 clears it, and both views read the new value at bit 0.
- R3: In the pending views, bit 4 (timer) and bit 8 (external) ignore writes. They read the timer and external input lines as sampled at the previous clock edge. All other bits read 0.
- R4: The user enable view (select 1) and the machine enable view (select 3) are the same storage: software enable at bit 0, timer enable at bit 4, external enable at bit 8. A write through either view reads back through both. Other bits read 0.
- R5: A pending interrupt whose enable bit is 0 produces no request, and it does not block a lower-priority interrupt that is enabled.
- R6: The machine delegation mask (select 4) keeps bits 0, 4 and 8. A bit of the supervisor delegation mask (select 5) takes a written 1 only where the machine mask bit is already 1. Elsewhere it reads 0.
- R7: A request is raised only when the privilege input is user (code 0), the global user enable input is 1, and at least one kind is pending, enabled and delegated through both masks. Privilege codes 1 and 3 block it.
- R8: When several kinds qualify together, external wins (cause 8), then software (cause 0), then timer (cause 4).
- R9: `irq_req_o` and `irq_cause_o` are registered. A change on an input line shows at the outputs after the second rising edge that follows it. The CSR read data appears one edge after the select is applied. Selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| uie_i | input | 1 | Global user interrupt enable from the status register |
| tmr_line_i | input | 1 | Raw user timer interrupt line |
| ext_line_i | input | 1 | Raw user external interrupt line |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 3 | Register select: 0 user pending, 1 user enable, 2 machine pending, 3 machine enable, 4 machine delegation, 5 supervisor delegation |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | Registered read data for the selected register |
| irq_req_o | output | 1 | Take-interrupt request |
| irq_cause_o | output | CAUSE_W | Cause code of the request (0, 4 or 8) |

## Verification
Priority resolution and masking meet in the same cycle whenever two or three interrupt kinds are pending together. The bench provokes this by raising the external and timer lines while it writes the software pending bit. It then clears single enable or delegation bits and checks that the cause moves to the next-ranked kind, or that the request drops. A second overlap occurs when a CSR write and a line change land on one edge. The bench checks that the ignored pending bits still follow the lines after such a write.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int SW_BIT  = 0;
  localparam int TMR_BIT = 4;
  localparam int EXT_BIT = 8;

  localparam int CODE_SW  = 0;
  localparam int CODE_TMR = 4;
  localparam int CODE_EXT = 8;

  localparam logic [1:0] PRIV_USER = 2'd0;

  // compact index: 0 software, 1 timer, 2 external
  localparam int K_SW  = 0;
  localparam int K_TMR = 1;
  localparam int K_EXT = 2;
  localparam int KINDS = 3;

  typedef enum logic [2:0] {
    SEL_UPEND = 3'd0,
    SEL_UEN   = 3'd1,
    SEL_MPEND = 3'd2,
    SEL_MEN   = 3'd3,
    SEL_MDLG  = 3'd4,
    SEL_SDLG  = 3'd5
  } csr_sel_e;
endpackage

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_S = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic [2:0]       csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  input  logic             tmr_line,
  input  logic             ext_line,
  output logic [KINDS-1:0] pend,
  output logic [KINDS-1:0] en,
  output logic [KINDS-1:0] deleg,
  output logic [XLEN-1:0]  rdata
);
  logic             usip_q, utip_q, ueip_q;
  logic [KINDS-1:0] en_q, mdlg_q, sdlg_q, sdlg_eff;
  logic [KINDS-1:0] wv;
  logic [XLEN-1:0]  view;

  function automatic logic [XLEN-1:0] spread(input logic [KINDS-1:0] v);
    logic [XLEN-1:0] r;
    r = '0;
    r[SW_BIT]  = v[K_SW];
    r[TMR_BIT] = v[K_TMR];
    r[EXT_BIT] = v[K_EXT];
    return r;
  endfunction

  assign wv = {csr_wdata[EXT_BIT], csr_wdata[TMR_BIT], csr_wdata[SW_BIT]};

  // line-driven pending bits are sampled every cycle
  always_ff @(posedge clk) begin
    utip_q <= tmr_line;
    ueip_q <= ext_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      usip_q <= 1'b0;
      en_q   <= '0;
      mdlg_q <= '0;
    end else if (csr_we) begin
      case (csr_sel)
        SEL_UPEND, SEL_MPEND: usip_q <= csr_wdata[SW_BIT];
        SEL_UEN,   SEL_MEN:   en_q   <= wv;
        SEL_MDLG:             mdlg_q <= wv;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_S) begin : g_two_level
      always_ff @(posedge clk) begin
        if (rst) sdlg_q <= '0;
        else if (csr_we && csr_sel == SEL_SDLG) sdlg_q <= wv & mdlg_q;
      end
      assign sdlg_eff = sdlg_q & mdlg_q;
      assign deleg    = sdlg_eff;
    end else begin : g_one_level
      assign sdlg_q   = '0;
      assign sdlg_eff = '0;
      assign deleg    = mdlg_q;
    end
  endgenerate

  assign pend = {ueip_q, utip_q, usip_q};
  assign en   = en_q;

  always_comb begin
    case (csr_sel)
      SEL_UPEND, SEL_MPEND: view = spread(pend);
      SEL_UEN,   SEL_MEN:   view = spread(en_q);
      SEL_MDLG:             view = spread(mdlg_q);
      SEL_SDLG:             view = spread(sdlg_eff);
      default:              view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= view;
  end

  assert_tmr_follows_line_R3: assert property (@(posedge clk) disable iff (rst)
    utip_q == $past(tmr_line));
  assert_ext_follows_line_R3: assert property (@(posedge clk) disable iff (rst)
    ueip_q == $past(ext_line));
  assert_sw_write_R2: assert property (@(posedge clk) disable iff (rst)
    (csr_we && (csr_sel == SEL_UPEND || csr_sel == SEL_MPEND))
      |=> usip_q == $past(csr_wdata[SW_BIT]));
  assert_enable_alias_R4: assert property (@(posedge clk) disable iff (rst)
    (csr_we && (csr_sel == SEL_UEN || csr_sel == SEL_MEN)) |=> en_q == $past(wv));
endmodule

// File: rtl/uirq_arb.sv
module uirq_arb
  import uirq_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         priv,
  input  logic               uie,
  input  logic [KINDS-1:0]   pend,
  input  logic [KINDS-1:0]   en,
  input  logic [KINDS-1:0]   deleg,
  output logic               req,
  output logic [CAUSE_W-1:0] cause
);
  logic [KINDS-1:0]   act;
  logic               gate;
  logic [CAUSE_W-1:0] cause_n;

  assign act  = pend & en & deleg;
  assign gate = (priv == PRIV_USER) && uie;

  always_comb begin
    if (act[K_EXT])     cause_n = CAUSE_W'(CODE_EXT);
    else if (act[K_SW]) cause_n = CAUSE_W'(CODE_SW);
    else                cause_n = CAUSE_W'(CODE_TMR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      cause <= '0;
    end else begin
      req   <= gate && (|act);
      cause <= (gate && (|act)) ? cause_n : '0;
    end
  end

  assert_user_only_R7: assert property (@(posedge clk) disable iff (rst)
    req |-> ($past(priv) == PRIV_USER && $past(uie)));
  assert_masked_R5: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(|(pend & en & deleg)));
  assert_ext_first_R8: assert property (@(posedge clk) disable iff (rst)
    (req && $past(pend[K_EXT] & en[K_EXT] & deleg[K_EXT])) |-> cause == CAUSE_W'(CODE_EXT));
  assert_cause_legal_R8: assert property (@(posedge clk) disable iff (rst)
    req |-> (cause == CAUSE_W'(CODE_EXT) || cause == CAUSE_W'(CODE_SW) ||
             cause == CAUSE_W'(CODE_TMR)));
endmodule

// File: rtl/uirq_route.sv
module uirq_route
  import uirq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4,
  parameter bit HAS_S   = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         priv_i,
  input  logic               uie_i,
  input  logic               tmr_line_i,
  input  logic               ext_line_i,
  input  logic               csr_we_i,
  input  logic [2:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               irq_req_o,
  output logic [CAUSE_W-1:0] irq_cause_o
);
  logic [KINDS-1:0] pend, en, deleg;

  uirq_regs #(.XLEN(XLEN), .HAS_S(HAS_S)) u_regs (
    .clk(clk), .rst(rst), .csr_we(csr_we_i), .csr_sel(csr_sel_i),
    .csr_wdata(csr_wdata_i), .tmr_line(tmr_line_i), .ext_line(ext_line_i),
    .pend(pend), .en(en), .deleg(deleg), .rdata(csr_rdata_o)
  );

  uirq_arb #(.CAUSE_W(CAUSE_W)) u_arb (
    .clk(clk), .rst(rst), .priv(priv_i), .uie(uie_i),
    .pend(pend), .en(en), .deleg(deleg),
    .req(irq_req_o), .cause(irq_cause_o)
  );
endmodule

// File: tb/uirq_route_bench.sv
module uirq_route_bench;
  localparam int XLEN = 32;
  localparam int CW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      priv = 2'd3;
  logic            uie = 1'b0, tmr = 1'b0, ext = 1'b0, we = 1'b0;
  logic [2:0]      sel = 3'd0;
  logic [XLEN-1:0] wdata = '0;
  logic [XLEN-1:0] rdata;
  logic            req;
  logic [CW-1:0]   cause;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uirq_route #(.XLEN(XLEN), .CAUSE_W(CW), .HAS_S(1'b1)) u_uirq_route (
    .clk(clk), .rst(rst), .priv_i(priv), .uie_i(uie), .tmr_line_i(tmr),
    .ext_line_i(ext), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .irq_req_o(req), .irq_cause_o(cause)
  );

  // {priv[1:0], uie, sw, tmr, ext, exp_req, exp_cause[3:0]}
  localparam logic [10:0] VEC [10] = '{
    11'b00_1_1_0_0_1_0000, // R8 software alone -> 0
    11'b00_1_0_1_0_1_0100, // R8 timer alone -> 4
    11'b00_1_0_0_1_1_1000, // R8 external alone -> 8
    11'b00_1_1_1_1_1_1000, // R8 all three -> external
    11'b00_1_1_1_0_1_0000, // R8 software beats timer
    11'b00_0_1_1_1_0_0000, // R7 global enable low
    11'b11_1_1_1_1_0_0000, // R7 machine mode
    11'b01_1_0_0_1_0_0000, // R7 supervisor mode
    11'b00_1_0_1_1_1_1000, // R8 external beats timer
    11'b00_1_0_0_0_0_0000  // R7 nothing pending
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] s, input logic [XLEN-1:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] s, output logic [XLEN-1:0] d);
    @(negedge clk);
    we = 1'b0; sel = s;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [XLEN-1:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req", {31'b0, req}, 32'd0);
    check("R1 rdata", rdata, 32'd0);
    rst = 1'b0;
    csr_read(3'd3, rd);  check("R1 enables", rd, 32'd0);
    csr_read(3'd4, rd);  check("R1 mdeleg", rd, 32'd0);

    // R4 alias of enables, R6 delegation masks
    csr_write(3'd1, 32'hFFFF_FFFF);
    csr_read(3'd3, rd);  check("R4 mie via uie", rd, 32'h111);
    csr_write(3'd3, 32'h0000_0010);
    csr_read(3'd1, rd);  check("R4 uie via mie", rd, 32'h010);
    csr_write(3'd5, 32'h111);
    csr_read(3'd5, rd);  check("R6 sideleg without mideleg", rd, 32'd0);
    csr_write(3'd4, 32'hFFFF_F011);
    csr_read(3'd4, rd);  check("R6 mideleg bits", rd, 32'h011);
    csr_write(3'd5, 32'h111);
    csr_read(3'd5, rd);  check("R6 sideleg subset", rd, 32'h011);
    csr_read(3'd6, rd);  check("R9 unused select", rd, 32'd0);

    // R2 / R3 pending views
    csr_write(3'd0, 32'h0000_0111);
    csr_read(3'd2, rd);  check("R2 R3 usip set, ro bits", rd, 32'h001);
    csr_write(3'd2, 32'h0);
    csr_read(3'd0, rd);  check("R2 usip cleared", rd, 32'h000);
    @(negedge clk); tmr = 1'b1; ext = 1'b1;
    csr_write(3'd0, 32'h0);
    csr_read(3'd0, rd);  check("R3 lines visible", rd, 32'h110);
    tmr = 1'b0; ext = 1'b0;

    // full delegation and enables for the table
    csr_write(3'd4, 32'h111);
    csr_write(3'd5, 32'h111);
    csr_write(3'd3, 32'h111);
    foreach (VEC[i]) begin
      @(negedge clk);
      priv = VEC[i][10:9]; uie = VEC[i][8];
      tmr = VEC[i][6]; ext = VEC[i][5];
      we = 1'b1; sel = 3'd0; wdata = {31'b0, VEC[i][7]};
      @(negedge clk); we = 1'b0;
      @(negedge clk);
      check($sformatf("R7 R8 vec%0d req", i), {31'b0, req}, {31'b0, VEC[i][4]});
      check($sformatf("R8 vec%0d cause", i), {28'b0, cause}, {28'b0, VEC[i][3:0]});
    end

    // R5 external pending but disabled; timer enabled takes over
    csr_write(3'd3, 32'h011);
    @(negedge clk); tmr = 1'b1; ext = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5 disabled external skipped", {28'b0, cause}, 32'd4);
    check("R5 req", {31'b0, req}, 32'd1);
    csr_write(3'd3, 32'h001);
    @(negedge clk);
    check("R5 all masked", {31'b0, req}, 32'd0);

    // R7 delegation removed for external
    csr_write(3'd3, 32'h111);
    csr_write(3'd4, 32'h011);
    @(negedge clk);
    check("R7 undelegated external", {28'b0, cause}, 32'd4);

    // R9 latency from line edge
    csr_write(3'd4, 32'h111);
    csr_write(3'd5, 32'h111);
    @(negedge clk); tmr = 1'b0; ext = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 idle", {31'b0, req}, 32'd0);
    ext = 1'b1;
    @(negedge clk);
    check("R9 one edge", {31'b0, req}, 32'd0);
    @(negedge clk);
    check("R9 two edges", {31'b0, req}, 32'd1);
    check("R9 cause", {28'b0, cause}, 32'd8);

    // R1 reset again
    rst = 1'b1;
    @(negedge clk);
    check("R1 req after reset", {31'b0, req}, 32'd0);
    rst = 1'b0;
    csr_read(3'd5, rd);  check("R1 sideleg after reset", rd, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule